// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Completion and Collision Flags

This block is a byte-wide serial peripheral port that sits on a small CPU register bus. The bus sees two registers: a data register and a status register. A write to the data register loads the 8-bit shift register. In master mode, the same write also starts a transfer, and the block generates the serial clock from a divided CPU clock. A read of the data register returns the byte captured by the most recent completed transfer. It does not return the live shift register.

In slave mode, the external serial clock, data input and select line pass through two-flop synchronisers into the CPU clock domain. The block shifts on the edges it detects on the synchronised clock. Both modes use clock mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge, and the most significant bit goes first.

The status register has three active bits: a completion flag, a write-collision flag and a speed-doubling control bit. The completion flag sets when a byte finishes. It also sets when the select line is pulled low while the port is master, and in that case the running transfer is abandoned. Software clears the flags in two steps: read the status register while the flag is set, then make any access to the data register. An interrupt acknowledge also clears the completion flag. An interrupt request is raised while the completion flag, the local enable and the global enable are all set.

Top module: `spi_port`

## Requirements
- R1: After reset, the status register (bus_addr=1) reads 0x00, the data register (bus_addr=0) reads 0x00, irq is 0 and sck_o is 0.
- R2: In master mode, a data-register write starts a transfer of 8 sck_o pulses. mosi_o carries the written byte MSB first, valid before each rising edge. miso_i is sampled on each rising edge, and the received byte is read back from the data register afterwards.
- R3: The sck_o half period in master mode is set by rate_sel: 0 gives 2, 1 gives 8, 2 gives 32 and 3 gives 64 CPU clocks, which divide the CPU clock by 4, 16, 64 and 128.
- R4: Writing 1 to status bit 0 halves every sck_o half period. With rate_sel=0 the sck_o period is then 2 CPU clocks.
- R5: Status bit 7 is the completion flag, bit 6 the collision flag and bit 0 the speed-doubling bit (read/write). Bits 5 to 1 read as zero even after a write of ones.
- R6: The completion flag sets when a byte transfer finishes. irq equals int_en AND gie AND the completion flag.
- R7: A one-cycle pulse on irq_ack clears the completion flag.
- R8: A data-register write while a transfer is running sets the collision flag. The written byte is discarded, and the running transfer finishes with its original byte.
- R9: A status read that sees a flag set, followed by a data-register read or write, clears that flag; a read that sees the collision flag set clears both flags. A data-register access with no such status read in between leaves the flags set.
- R10: If the completion flag is set again between the status read and the data-register access, it survives that access.
- R11: In master mode, a falling level on ss_n_i sets the completion flag, stops the running transfer and leaves sck_o low.
- R12: In slave mode, with ss_n_i low, the port receives 8 bits from mosi_i on rising sck_i edges into the data register and sets the completion flag. It drives the byte loaded before the transfer on miso_o, MSB first. It works for sck_i half periods down to 2 CPU clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_en | input | 1 | Port enable |
| is_master | input | 1 | 1 selects master mode, 0 slave mode |
| int_en | input | 1 | Local interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rate_sel | input | 2 | Master clock divider select |
| bus_addr | input | 1 | Register select: 0 data, 1 status |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| ss_n_i | input | 1 | Active-low select input |

## Verification
Two functions can meet in the same cycle: the completion flag being set again, and the two-step clear that would remove it. The bench provokes this overlap by reading status to arm the clear. It then pulls the select line low in master mode so that the flag sets again, and only after that accesses the data register. It judges the result by a status read, which must still show the flag. A second overlap is a data-register write that lands during a running transfer. That case is judged by the byte seen on the serial output and by the collision flag.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_en,
  input  logic          is_master,
  input  logic          int_en,
  input  logic          gie,
  input  logic [1:0]    rate_sel,
  input  logic          bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_ack,
  output logic          irq,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          ss_n_i
);
  localparam int BW = $clog2(DW);
  localparam int CW = 7;

  logic [2:0] sy1, sy2;
  logic sck_d, ss_d;
  logic [DW-1:0] sr, rbuf;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] cnt, base, half;
  logic rx_bit, run, sck_q, dbl, spif, wcol, arm_f, arm_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= 3'b100; sy2 <= 3'b100; sck_d <= 1'b0; ss_d <= 1'b1;
    end else begin
      sy1 <= {ss_n_i, mosi_i, sck_i};
      sy2 <= sy1;
      sck_d <= sy2[0];
      ss_d <= sy2[2];
    end

  wire sck_s = sy2[0];
  wire mosi_s = sy2[1];
  wire ss_s = sy2[2];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire mst = spi_en & is_master;
  wire slv = spi_en & ~is_master;
  wire modf = mst & ~ss_s & ss_d;
  wire wr_dat = bus_we & ~bus_addr;
  wire wr_st = bus_we & bus_addr;
  wire rd_st = bus_re & bus_addr;
  wire acc_dat = (bus_we | bus_re) & ~bus_addr;
  wire collide = wr_dat & run;
  wire last_bit = (bcnt == BW'(DW - 1));
  wire tick = mst & run & (cnt == half - 1'b1);
  wire m_last = tick & sck_q & last_bit;
  wire s_last = slv & run & ~ss_s & sck_fall & last_bit;
  wire done_evt = m_last | s_last | modf;

  always_comb begin
    case (rate_sel)
      2'd0:    base = 7'd2;
      2'd1:    base = 7'd8;
      2'd2:    base = 7'd32;
      default: base = 7'd64;
    endcase
    half = dbl ? (base >> 1) : base;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; rbuf <= '0; bcnt <= '0; cnt <= '0;
      rx_bit <= 1'b0; run <= 1'b0; sck_q <= 1'b0;
    end else begin
      if (wr_dat && !run) begin
        sr <= bus_wdata;
        if (mst) begin
          run <= 1'b1; cnt <= '0; bcnt <= '0; sck_q <= 1'b0;
        end
      end
      if (modf || !spi_en) begin
        run <= 1'b0; sck_q <= 1'b0; cnt <= '0; bcnt <= '0;
      end else if (mst) begin
        if (run) begin
          if (tick) begin
            cnt <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_bit <= miso_i;
            end else begin
              sck_q <= 1'b0;
              sr <= {sr[DW-2:0], rx_bit};
              bcnt <= bcnt + 1'b1;
              if (last_bit) begin
                run <= 1'b0;
                rbuf <= {sr[DW-2:0], rx_bit};
                bcnt <= '0;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (ss_s) begin
        run <= 1'b0; bcnt <= '0;
      end else begin
        if (sck_rise) begin
          rx_bit <= mosi_s;
          run <= 1'b1;
        end
        if (sck_fall && run) begin
          sr <= {sr[DW-2:0], rx_bit};
          bcnt <= bcnt + 1'b1;
          if (last_bit) begin
            run <= 1'b0;
            rbuf <= {sr[DW-2:0], rx_bit};
            bcnt <= '0;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      spif <= 1'b0; wcol <= 1'b0; arm_f <= 1'b0; arm_w <= 1'b0; dbl <= 1'b0;
    end else begin
      spif <= done_evt | (spif & ~((acc_dat & (arm_f | arm_w)) | irq_ack));
      wcol <= collide | (wcol & ~(acc_dat & arm_w));
      if (done_evt) arm_f <= 1'b0;
      else if (rd_st && spif) arm_f <= 1'b1;
      else if (acc_dat) arm_f <= 1'b0;
      if (collide) arm_w <= 1'b0;
      else if (rd_st && wcol) arm_w <= 1'b1;
      else if (acc_dat) arm_w <= 1'b0;
      if (wr_st) dbl <= bus_wdata[0];
    end

  assign bus_rdata = bus_addr ? {spif, wcol, {(DW-3){1'b0}}, dbl} : rbuf;
  assign irq = int_en & gie & spif;
  assign sck_o = sck_q;
  assign mosi_o = sr[DW-1];
  assign miso_o = sr[DW-1];

  a_r8_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wcol);
  a_r8_shift_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && mst && !done_evt) |=> run);
  a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> spif);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done_evt) |=> !spif);
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    modf |=> (!run && !sck_o));
endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_en = 1'b0, is_master = 1'b1, int_en = 1'b0, gie = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic bus_addr = 1'b0, bus_we = 1'b0, bus_re = 1'b0, irq_ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic irq, sck_o, mosi_o, miso_i, sck_i = 1'b0, mosi_i = 1'b0, miso_o, ss_n_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$], got_q[$];
  logic [7:0] m_sr = 8'h00, mcap = 8'h00;
  realtime t_prev = 0, per = 0;
  int n_rise = 0;

  always #10 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .is_master(is_master),
    .int_en(int_en), .gie(gie), .rate_sel(rate_sel), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
  );

  assign miso_i = m_sr[7];
  always @(negedge sck_o) m_sr <= {m_sr[6:0], 1'b0};
  always @(posedge sck_o) begin
    mcap <= {mcap[6:0], mosi_o};
    if (n_rise > 0) per = $realtime - t_prev;
    t_prev = $realtime;
    n_rise++;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk)
    while (got_q.size() > 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk("R2 scoreboard empty", g, 8'hxx);
      else chk("R2/R12 data register", g, exp_q.pop_front());
    end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; #1 v = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic sb_read(input logic [7:0] e);
    logic [7:0] v;
    exp_q.push_back(e);
    rd(1'b0, v);
    got_q.push_back(v);
  endtask

  task automatic clr_flags();
    logic [7:0] v;
    rd(1'b1, v);
    rd(1'b0, v);
  endtask

  task automatic xfer_m(input logic [7:0] tx, input logic [7:0] resp, input logic [1:0] rs,
                        input logic d, input int half);
    logic [7:0] v;
    rate_sel = rs;
    wr(1'b1, {7'b0, d});
    m_sr = resp; n_rise = 0;
    wr(1'b0, tx);
    repeat (16 * half + 8) @(negedge clk);
    chk("R2 mosi byte", mcap, tx);
    chk("R2 pulse count", n_rise, 8);
    chk("R3/R4 sck period", int'(per), 40 * half);
    v = 8'h00;
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input int hp, output logic [7:0] cap);
    cap = 8'h00;
    @(negedge clk); ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = tx[i];
      repeat (hp) @(negedge clk);
      sck_i = 1'b1; cap = {cap[6:0], miso_o};
      repeat (hp) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b1, v); chk("R1 status reset", v, 8'h00);
    rd(1'b0, v); chk("R1 data reset", v, 8'h00);
    chk("R1 irq reset", irq, 0);
    chk("R1 sck reset", sck_o, 0);

    spi_en = 1'b1; is_master = 1'b1;
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R5 reserved bits zero", v, 8'h01);
    wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R5 double bit cleared", v, 8'h00);

    xfer_m(8'hA5, 8'h3C, 2'd0, 1'b0, 2);
    int_en = 1'b1; gie = 1'b0; #1;
    chk("R6 irq gated by global enable", irq, 0);
    rd(1'b1, v); chk("R6 completion flag", v, 8'h80);
    sb_read(8'h3C);
    rd(1'b1, v); chk("R9 flag cleared by sequence", v, 8'h00);
    int_en = 1'b0;

    xfer_m(8'h5A, 8'hC3, 2'd0, 1'b1, 1);
    rd(1'b1, v); chk("R4 status with double", v, 8'h81);
    sb_read(8'hC3);
    xfer_m(8'h0F, 8'hF0, 2'd3, 1'b1, 32);
    clr_flags();
    xfer_m(8'h81, 8'h7E, 2'd1, 1'b0, 8);
    sb_read(8'h7E);
    rd(1'b1, v); chk("R9 data access alone keeps flag", v, 8'h80);
    sb_read(8'h7E);
    rd(1'b1, v); chk("R9 cleared after armed access", v, 8'h00);

    rate_sel = 2'd1; m_sr = 8'h99; n_rise = 0;
    wr(1'b0, 8'h6C);
    repeat (40) @(negedge clk);
    wr(1'b0, 8'hFF);
    repeat (140) @(negedge clk);
    chk("R8 original byte shifted", mcap, 8'h6C);
    rd(1'b1, v); chk("R8 collision and done flags", v, 8'hC0);
    sb_read(8'h99);
    rd(1'b1, v); chk("R9 both flags cleared", v, 8'h00);

    xfer_m(8'h33, 8'h44, 2'd0, 1'b0, 2);
    int_en = 1'b1; gie = 1'b1; #1;
    chk("R6 irq raised", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0; #1;
    chk("R7 irq after ack", irq, 0);
    rd(1'b1, v); chk("R7 flag cleared by ack", v, 8'h00);
    int_en = 1'b0; gie = 1'b0;
    sb_read(8'h44);

    xfer_m(8'h12, 8'h34, 2'd0, 1'b0, 2);
    rd(1'b1, v); chk("R10 flag armed", v, 8'h80);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    sb_read(8'h34);
    rd(1'b1, v); chk("R10 re-set flag survives", v, 8'h80);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    clr_flags();
    rd(1'b1, v); chk("R10 cleared afterwards", v, 8'h00);

    rate_sel = 2'd1; n_rise = 0;
    wr(1'b0, 8'hAA);
    repeat (30) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    begin
      int highs = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (sck_o) highs++;
      end
      chk("R11 sck held low", highs, 0);
    end
    rd(1'b1, v); chk("R11 mode fault sets flag", v, 8'h80);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    clr_flags();

    is_master = 1'b0;
    wr(1'b0, 8'h5A);
    slave_xfer(8'h96, 8, cap);
    chk("R12 slave miso byte", cap, 8'h5A);
    rd(1'b1, v); chk("R12 slave completion", v, 8'h80);
    sb_read(8'h96);
    wr(1'b0, 8'h00);
    slave_xfer(8'h3B, 2, cap);
    rd(1'b1, v); chk("R12 fast slave completion", v, 8'h80);
    sb_read(8'h3B);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule